// File: doc/BRIEF.md
# Decimal Real-Time Interrupt Divider

This block generates a periodic interrupt by dividing its input clock by a ratio built on decimal steps. A 7-bit rate value holds two fields. The upper three bits pick a prescale base from a 1-2-5 decade ladder that runs from one thousand to two hundred thousand clocks. The lower four bits pick an integer multiplier from 1 to 16. A separate mode bit turns decimal division on. The longest period is 3.2 million input clocks.

Inside, a prescale counter counts up to the base. Each time it reaches the base, it advances a multiplier counter. When both counters wrap on the same cycle, a sticky flag sets. Software clears the flag by pulsing a one on the clear input. The interrupt output is the flag gated by an enable bit, which is written together with the rate.

A two-state controller runs the counters. In ST_IDLE the counters are held at zero. In ST_RUN they count. A configuration write with the mode bit at 1 takes the transition START (ST_IDLE to ST_RUN) or RESTART (ST_RUN to ST_RUN). A write with the mode bit at 0 takes the transition STOP (ST_RUN to ST_IDLE) or STAY (ST_IDLE to ST_IDLE). Every write clears both counters, so the first period after a write has the full new length.

Top module: `dec_rti_divider`

## Requirements
- R1: With decimal mode on, the flag sets exactly base × multiplier input clocks after the clock edge that accepted the write, and then again every base × multiplier clocks.
- R2: Rate bits [6:4] select the base: 0→1000, 1→2000, 2→5000, 3→10000, 4→20000, 5→50000, 6→100000, 7→200000.
- R3: Rate bits [3:0] select a multiplier equal to the field value plus one, so 0 divides by 1 and 15 divides by 16.
- R4: Any configuration write clears both counters on the accepting edge. This restarts the period from zero. A write does not change the flag.
- R5: Once set, the flag stays at 1 until flag_clr is high at a clock edge. It reads 0 after that edge.
- R6: If a period ends on the same edge where flag_clr is high, the flag ends up set.
- R7: rti_irq is 1 exactly when the flag is 1 and the written enable bit is 1.
- R8: With the mode bit written as 0, the counters are held and the flag never sets.
- R9: After reset the flag and the interrupt are 0, decimal mode is off and the controller is in ST_IDLE.
- R10: Neither counter ever passes its terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rate | input | 7 | Rate value: [6:4] base select, [3:0] multiplier minus one |
| cfg_dec_mode | input | 1 | 1 enables decimal division |
| cfg_irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| rti_flag | output | 1 | Sticky period-elapsed flag |
| rti_irq | output | 1 | Flag gated by the enable |

## Verification
The bench measures exact periods in clocks for the smallest ratio, for several bases and multipliers, and for random small settings. An off-by-one in either counter would move the flag edge by one clock or by a whole base. A rate change is made in the middle of a period. A design that does not restart would flag early, at the old phase. The bench holds flag_clr high on the very edge where a period ends, so a design that gives priority to the clear would lose the event. It also checks that the flag stays quiet with decimal mode off, and that the enable masks only the interrupt and never the flag.

// File: rtl/dec_rti_pkg.sv
package dec_rti_pkg;

    localparam int SEL_W_DEF = 3;
    localparam int MUL_W_DEF = 4;
    localparam int PSC_W_DEF = 18;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rti_state_e;

    // terminal count (base minus one) of the prescaler for a base select code
    function automatic logic [31:0] psc_terminal(input logic [2:0] sel);
        logic [31:0] base;
        unique case (sel)
            3'd0: base = 32'd1000;
            3'd1: base = 32'd2000;
            3'd2: base = 32'd5000;
            3'd3: base = 32'd10000;
            3'd4: base = 32'd20000;
            3'd5: base = 32'd50000;
            3'd6: base = 32'd100000;
            default: base = 32'd200000;
        endcase
        return base - 32'd1;
    endfunction

endpackage

// File: rtl/dec_rti_cfg.sv
module dec_rti_cfg
    import dec_rti_pkg::*;
#(
    parameter int SEL_W = SEL_W_DEF,
    parameter int MUL_W = MUL_W_DEF,
    parameter int PSC_W = PSC_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [SEL_W+MUL_W-1:0] rate_i,
    input  logic                   dec_i,
    input  logic                   en_i,
    output logic [PSC_W-1:0]       psc_term_o,
    output logic [MUL_W-1:0]       mul_term_o,
    output logic                   en_o
);

    localparam int RATE_W = SEL_W + MUL_W;

    logic [SEL_W-1:0] sel_w;
    logic [31:0]      term_w;
    logic             dec_unused;

    assign sel_w      = rate_i[RATE_W-1:MUL_W];
    assign term_w     = psc_terminal(3'(sel_w));
    assign dec_unused = dec_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_term_o <= PSC_W'(psc_terminal(3'd0));
            mul_term_o <= '0;
            en_o       <= 1'b0;
        end else if (we_i) begin
            psc_term_o <= PSC_W'(term_w);
            mul_term_o <= rate_i[MUL_W-1:0];
            en_o       <= en_i;
        end
    end

endmodule

// File: rtl/dec_rti_ctrl.sv
module dec_rti_ctrl
    import dec_rti_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic dec_i,
    output logic run_o,
    output logic restart_o
);

    rti_state_e state_q;
    rti_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (we_i && dec_i)  state_d = ST_RUN;   // START
            ST_RUN:  if (we_i && !dec_i) state_d = ST_IDLE;  // STOP
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run_o     = (state_q == ST_RUN);
        restart_o = we_i;
    end

    // R9
    reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> state_q == ST_IDLE);

    // R8
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !dec_i) |=> !run_o);

endmodule

// File: rtl/dec_rti_prescaler.sv
module dec_rti_prescaler #(
    parameter int PSC_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PSC_W-1:0] term_i,
    output logic             tick_o
);

    logic [PSC_W-1:0] cnt_q;
    logic             at_term;

    assign at_term = (cnt_q == term_i);
    assign tick_o  = run_i && !restart_i && at_term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (restart_i || !run_i) cnt_q <= '0;
        else if (at_term)           cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    // R10
    psc_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= term_i);

    // R4
    psc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> cnt_q == '0);

endmodule

// File: rtl/dec_rti_multiplier.sv
module dec_rti_multiplier #(
    parameter int MUL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [MUL_W-1:0] term_i,
    output logic             wrap_o
);

    logic [MUL_W-1:0] cnt_q;

    assign wrap_o = tick_i && (cnt_q == term_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (restart_i || !run_i) cnt_q <= '0;
        else if (wrap_o)              cnt_q <= '0;
        else if (tick_i)              cnt_q <= cnt_q + 1'b1;
    end

    // R10
    mul_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= term_i);

    // R3
    mul_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && !tick_i) |=> $stable(cnt_q));

    // R4
    mul_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> cnt_q == '0);

endmodule

// File: rtl/dec_rti_flag.sv
module dec_rti_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> flag_o);

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/dec_rti_divider.sv
module dec_rti_divider
    import dec_rti_pkg::*;
#(
    parameter int SEL_W = SEL_W_DEF,
    parameter int MUL_W = MUL_W_DEF,
    parameter int PSC_W = PSC_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [SEL_W+MUL_W-1:0] cfg_rate,
    input  logic                   cfg_dec_mode,
    input  logic                   cfg_irq_en,
    input  logic                   flag_clr,
    output logic                   rti_flag,
    output logic                   rti_irq
);

    logic [PSC_W-1:0] psc_term;
    logic [MUL_W-1:0] mul_term;
    logic             en_q;
    logic             run;
    logic             restart;
    logic             tick;
    logic             wrap;

    dec_rti_cfg #(.SEL_W(SEL_W), .MUL_W(MUL_W), .PSC_W(PSC_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .rate_i(cfg_rate),
        .dec_i(cfg_dec_mode), .en_i(cfg_irq_en),
        .psc_term_o(psc_term), .mul_term_o(mul_term), .en_o(en_q)
    );

    dec_rti_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .dec_i(cfg_dec_mode),
        .run_o(run), .restart_o(restart)
    );

    dec_rti_prescaler #(.PSC_W(PSC_W)) psc_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart),
        .term_i(psc_term), .tick_o(tick)
    );

    dec_rti_multiplier #(.MUL_W(MUL_W)) mul_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart),
        .tick_i(tick), .term_i(mul_term), .wrap_o(wrap)
    );

    dec_rti_flag flag_i (
        .clk(clk), .rst_n(rst_n), .set_i(wrap), .clr_i(flag_clr), .flag_o(rti_flag)
    );

    assign rti_irq = rti_flag & en_q;

    // R8
    idle_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !rti_flag) |=> !rti_flag);

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_irq_en) |=> !rti_irq);

    // R4
    write_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && rti_flag && !flag_clr) |=> rti_flag);

endmodule

// File: tb/dec_rti_divider_tb.sv
module dec_rti_divider_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_rate = '0;
    logic       cfg_dec_mode = 1'b0;
    logic       cfg_irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       rti_flag;
    logic       rti_irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dec_rti_divider dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rate(cfg_rate),
        .cfg_dec_mode(cfg_dec_mode), .cfg_irq_en(cfg_irq_en),
        .flag_clr(flag_clr), .rti_flag(rti_flag), .rti_irq(rti_irq)
    );

    function automatic int exp_base(input int sel);
        int mant;
        int dec;
        mant = (sel % 3 == 0) ? 1 : (sel % 3 == 1) ? 2 : 5;
        dec = 1000;
        for (int k = 0; k < sel / 3; k++) dec = dec * 10;
        return mant * dec;
    endfunction

    function automatic int exp_period(input int sel, input int field);
        return exp_base(sel) * (field + 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // write config; returns bench cycle number of the accepting edge
    task automatic cfg_write(input int sel, input int field, input bit dec,
                             input bit en, output int w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_rate = {3'(sel), 4'(field)};
        cfg_dec_mode = dec;
        cfg_irq_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
        w = cyc;
    endtask

    task automatic wait_flag(input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (rti_flag) begin
                at = cyc;
                return;
            end
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic period_test(input string req, input int sel, input int field,
                               input bit two);
        int w, f1, f2, p;
        p = exp_period(sel, field);
        cfg_write(sel, field, 1'b1, 1'b1, w);
        wait_flag(p + 10, f1);
        check(req, f1 - w, p);
        if (two) begin
            clear_flag();
            check("R5 cleared", int'(rti_flag), 0);
            wait_flag(p + 10, f2);
            check(req, f2 - f1, p);
        end
        clear_flag();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int w, f, seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 flag", int'(rti_flag), 0);
        check("R9 irq", int'(rti_irq), 0);
        rst_n = 1'b1;
        repeat (1200) @(negedge clk);
        check("R9 idle after reset", int'(rti_flag), 0);

        // R1 R3 smallest ratio, two periods
        period_test("R1 smallest", 0, 0, 1'b1);
        // R3 multiplier 6
        period_test("R3 x6", 0, 5, 1'b1);
        // R2 base 5000, mid-range ratio
        period_test("R2 5000x3", 2, 2, 1'b0);
        period_test("R2 10000x1", 3, 0, 1'b0);
        period_test("R2 2000x2", 1, 1, 1'b0);

        // R4 rate change mid-period restarts count
        cfg_write(0, 2, 1'b1, 1'b1, w);
        repeat (1500) @(negedge clk);
        cfg_write(1, 0, 1'b1, 1'b1, w);
        wait_flag(2100, f);
        check("R4 restart", f - w, 2000);
        // R5 sticky
        repeat (50) @(negedge clk);
        check("R5 sticky", int'(rti_flag), 1);
        // R7 irq follows flag with enable
        check("R7 irq on", int'(rti_irq), 1);
        // R4 write keeps flag, R7 masked irq
        cfg_write(0, 0, 1'b1, 1'b0, w);
        check("R4 flag kept", int'(rti_flag), 1);
        check("R7 irq masked", int'(rti_irq), 0);
        cfg_write(0, 0, 1'b1, 1'b1, w);
        check("R7 irq back", int'(rti_irq), 1);
        clear_flag();
        check("R5 clear", int'(rti_flag), 0);

        // R6 set and clear on same edge
        cfg_write(0, 0, 1'b1, 1'b1, w);
        while (cyc != w + 999) @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R6 set wins", int'(rti_flag), 1);
        clear_flag();

        // R8 decimal mode off
        cfg_write(0, 0, 1'b0, 1'b1, w);
        wait_flag(3000, f);
        check("R8 no flag when off", f, -1);

        // random settings, R1 R2 R3
        for (int i = 0; i < 4; i++) begin
            int s, m;
            s = int'($urandom % 2);
            m = int'($urandom % 3);
            period_test("R1 random", s, m, 1'b1);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule